// File: doc/BRIEF.md
# CAN Error State Tracker

This block follows the fault-confinement level of one CAN controller. It keeps a receive error counter and a transmit error counter, which are moved by increment and decrement strobes from the protocol engine. From those counters it derives the level: error-active, warning, error-passive or bus-off. The counters and the level flags are published together in a 32-bit status word. A one-cycle event strobe fires whenever the level changes.

When a transmit increment would push the transmit counter past its maximum, the controller goes bus-off. At that moment the block raises a one-cycle abort request that marks all sixteen transmit slots. While bus-off, counter strobes are ignored. Recovery begins only when the host issues a restart request. The block then counts idle periods on the sampled bus line. An idle period is eleven consecutive recessive bits, and 128 of them are needed. When the last one completes, both counters clear, the level returns to error-active and the event strobe fires.

The controller has five states. ACTIVE, WARNING and PASSIVE follow the counters. Each of them moves to BUSOFF_WAIT on a transmit overflow. BUSOFF_WAIT moves to BUSOFF_RECOVER on a restart request. BUSOFF_RECOVER moves back to ACTIVE when the idle count completes.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset the status word is zero. Status bits 7:0 carry the receive counter and bits 15:8 the transmit counter. Bits 16 and 20 to 31 always read zero.
- R2: A receive increment strobe adds 1 to the receive counter, which saturates at 255. A transmit increment strobe adds 8. A decrement strobe subtracts 1 and stops at 0. When increment and decrement hit the same counter in the same cycle, the increment wins and the decrement is dropped.
- R3: Status bit 17 (warning) is set while either counter is at least 96. Status bit 18 (passive) is set while either counter is at least 128.
- R4: The event output pulses for exactly one cycle each time the level changes. The levels are bus-off, then passive, then warning, then active, in that order of precedence. A change toward a lower level also produces the pulse.
- R5: A transmit increment that would take the transmit counter above 255 enters bus-off. The transmit counter then reads 255, status bit 19 sets and the event pulses.
- R6: On entry to bus-off, the abort output pulses for one cycle with the 16-bit slot mask all ones. At all other times the mask is zero.
- R7: While bus-off, all counter strobes are ignored and the status word does not change.
- R8: Bus bits seen before the restart request are not counted, including a bit in the same cycle as the request. A restart request outside bus-off has no effect.
- R9: After the restart, 128 idle periods of 11 consecutive recessive bits (level input 1 with the bit strobe) return the block to error-active. Both counters clear and the event pulses.
- R10: A dominant bit (level input 0 with the bit strobe) during recovery discards the partial run of recessive bits.
- R11: Counter strobes in the same cycle as the bit that completes recovery are ignored, so the status word reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_err_inc_i | input | 1 | Receive error counter increment strobe |
| rx_err_dec_i | input | 1 | Receive error counter decrement strobe |
| tx_err_inc_i | input | 1 | Transmit error counter increment strobe |
| tx_err_dec_i | input | 1 | Transmit error counter decrement strobe |
| bit_valid_i | input | 1 | Sampled bus bit strobe |
| bit_level_i | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| restart_req_i | input | 1 | Host request to start bus-off recovery |
| status_o | output | 32 | Packed counters and level flags |
| state_event_o | output | 1 | One-cycle pulse on level change |
| tx_abort_o | output | 1 | One-cycle abort request on bus-off entry |
| tx_abort_mask_o | output | 16 | Transmit slots to abort, all ones with the request |

## Verification
Two events can land in the same cycle. The first is the recessive bit that completes recovery together with counter increment strobes. The bench drives receive and transmit increments alongside that final bit and expects a status word of exactly zero. The second is a restart request together with a bit strobe. The bench drives both at once and then shows that exactly 1408 further recessive bits are still needed: one fewer leaves bus-off set, and one more clears it.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE,
        ST_WARNING,
        ST_PASSIVE,
        ST_BUSOFF_WAIT,
        ST_BUSOFF_RECOVER
    } cft_state_e;

    typedef enum logic [1:0] {
        LVL_ACTIVE,
        LVL_WARNING,
        LVL_PASSIVE,
        LVL_BUSOFF
    } cft_level_e;

    localparam int STAT_W        = 32;
    localparam int STAT_RX_LSB   = 0;
    localparam int STAT_TX_LSB   = 8;
    localparam int STAT_WARN_POS = 17;
    localparam int STAT_PASS_POS = 18;
    localparam int STAT_BOFF_POS = 19;

    function automatic cft_level_e level_of(cft_state_e s);
        cft_level_e l;
        unique case (s)
            ST_ACTIVE:         l = LVL_ACTIVE;
            ST_WARNING:        l = LVL_WARNING;
            ST_PASSIVE:        l = LVL_PASSIVE;
            ST_BUSOFF_WAIT:    l = LVL_BUSOFF;
            ST_BUSOFF_RECOVER: l = LVL_BUSOFF;
            default:           l = LVL_ACTIVE;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/cft_err_counter.sv
module cft_err_counter #(
    parameter int CNT_W    = 8,
    parameter int STEP     = 1,
    parameter bit OVF_TRAP = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic             hold_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    localparam logic [CNT_W:0] MAX_EXT  = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0] STEP_EXT = (CNT_W+1)'(STEP);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   sum;
    logic             over;

    assign sum  = {1'b0, cnt_q} + STEP_EXT;
    assign over = sum > MAX_EXT;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (!hold_i) begin
            if (inc_i) begin
                cnt_d = over ? MAX_EXT[CNT_W-1:0] : sum[CNT_W-1:0];
            end else if (dec_i && (cnt_q != '0)) begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (OVF_TRAP) begin : g_trap
            assign ovf_o = inc_i && !hold_i && !clr_i && over;
        end else begin : g_no_trap
            assign ovf_o = 1'b0;
        end
    endgenerate

    assign cnt_o = cnt_q;

    // R2: decrement at zero leaves the counter at zero
    assert_dec_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !hold_i && !inc_i && dec_i && cnt_q == '0) |=> (cnt_q == '0));

    // R7: a held counter does not move
    assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/cft_idle_counter.sv
module cft_idle_counter #(
    parameter int IDLE_BITS  = 11,
    parameter int IDLE_COUNT = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic bit_valid_i,
    input  logic bit_recessive_i,
    output logic done_o
);
    localparam int RUN_W = $clog2(IDLE_BITS + 1);
    localparam int IDL_W = $clog2(IDLE_COUNT + 1);
    localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(IDLE_BITS - 1);
    localparam logic [IDL_W-1:0] IDLE_LAST = IDL_W'(IDLE_COUNT - 1);

    logic [RUN_W-1:0] run_q;
    logic [IDL_W-1:0] idl_q;
    logic             run_end;

    assign run_end = (run_q == RUN_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            idl_q <= '0;
        end else if (!en_i) begin
            run_q <= '0;
            idl_q <= '0;
        end else if (bit_valid_i) begin
            if (!bit_recessive_i) begin
                run_q <= '0;
            end else if (run_end) begin
                run_q <= '0;
                idl_q <= idl_q + 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign done_o = en_i && bit_valid_i && bit_recessive_i && run_end && (idl_q == IDLE_LAST);

    // R10: a dominant bit discards the partial run
    assert_dominant_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && bit_valid_i && !bit_recessive_i) |=> (run_q == '0));

    // R8: nothing accumulates while recovery is not enabled
    assert_no_count_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (run_q == '0 && idl_q == '0));

    // R9: run length never reaches the idle period length
    assert_run_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LAST);

endmodule

// File: rtl/cft_state_fsm.sv
module cft_state_fsm
    import can_fault_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128,
    parameter int SLOTS    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic [CNT_W-1:0] tx_cnt_i,
    input  logic             tx_ovf_i,
    input  logic             restart_i,
    input  logic             idle_done_i,
    output logic             busoff_o,
    output logic             cnt_hold_o,
    output logic             cnt_clr_o,
    output logic             recover_en_o,
    output logic             event_o,
    output logic             abort_o,
    output logic [SLOTS-1:0] abort_mask_o
);
    localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LIM);

    cft_state_e state_q, state_d, count_state;
    logic       event_q, abort_q;

    always_comb begin
        if (rx_cnt_i >= PASS_C || tx_cnt_i >= PASS_C)      count_state = ST_PASSIVE;
        else if (rx_cnt_i >= WARN_C || tx_cnt_i >= WARN_C) count_state = ST_WARNING;
        else                                               count_state = ST_ACTIVE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE, ST_WARNING, ST_PASSIVE: begin
                if (tx_ovf_i) state_d = ST_BUSOFF_WAIT;
                else          state_d = count_state;
            end
            ST_BUSOFF_WAIT: begin
                if (restart_i) state_d = ST_BUSOFF_RECOVER;
            end
            ST_BUSOFF_RECOVER: begin
                if (idle_done_i) state_d = ST_ACTIVE;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            event_q <= (level_of(state_d) != level_of(state_q));
            abort_q <= (state_d == ST_BUSOFF_WAIT) && (state_q != ST_BUSOFF_WAIT);
        end
    end

    assign busoff_o     = (level_of(state_q) == LVL_BUSOFF);
    assign cnt_hold_o   = busoff_o;
    assign recover_en_o = (state_q == ST_BUSOFF_RECOVER);
    assign cnt_clr_o    = recover_en_o && idle_done_i;
    assign event_o      = event_q;
    assign abort_o      = abort_q;
    assign abort_mask_o = {SLOTS{abort_q}};

    // R6: abort only in the first cycle of bus-off
    assert_abort_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_q |-> (state_q == ST_BUSOFF_WAIT && $past(state_q) != ST_BUSOFF_WAIT));

    // R5: bus-off is held until the host restarts
    assert_busoff_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSOFF_WAIT && !restart_i) |=> (state_q == ST_BUSOFF_WAIT));

    // R9: completed recovery lands in error-active with an event
    assert_recover_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSOFF_RECOVER && idle_done_i) |=> (state_q == ST_ACTIVE && event_q));

    // R4: every event marks a real level change
    assert_event_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        event_q |-> (level_of(state_q) != level_of($past(state_q))));

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
    import can_fault_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int RX_STEP    = 1,
    parameter int TX_STEP    = 8,
    parameter int WARN_LIM   = 96,
    parameter int PASS_LIM   = 128,
    parameter int IDLE_BITS  = 11,
    parameter int IDLE_COUNT = 128,
    parameter int SLOTS      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_err_inc_i,
    input  logic              rx_err_dec_i,
    input  logic              tx_err_inc_i,
    input  logic              tx_err_dec_i,
    input  logic              bit_valid_i,
    input  logic              bit_level_i,
    input  logic              restart_req_i,
    output logic [31:0]       status_o,
    output logic              state_event_o,
    output logic              tx_abort_o,
    output logic [SLOTS-1:0]  tx_abort_mask_o
);
    localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LIM);

    logic [CNT_W-1:0] rx_cnt, tx_cnt;
    logic             rx_ovf_unused, tx_ovf;
    logic             busoff, hold, clr, rec_en, idle_done;

    cft_err_counter #(.CNT_W(CNT_W), .STEP(RX_STEP), .OVF_TRAP(1'b0)) u_rx_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(rx_err_inc_i), .dec_i(rx_err_dec_i),
        .hold_i(hold), .clr_i(clr), .cnt_o(rx_cnt), .ovf_o(rx_ovf_unused)
    );

    cft_err_counter #(.CNT_W(CNT_W), .STEP(TX_STEP), .OVF_TRAP(1'b1)) u_tx_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(tx_err_inc_i), .dec_i(tx_err_dec_i),
        .hold_i(hold), .clr_i(clr), .cnt_o(tx_cnt), .ovf_o(tx_ovf)
    );

    cft_idle_counter #(.IDLE_BITS(IDLE_BITS), .IDLE_COUNT(IDLE_COUNT)) u_idle (
        .clk(clk), .rst_n(rst_n), .en_i(rec_en), .bit_valid_i(bit_valid_i),
        .bit_recessive_i(bit_level_i), .done_o(idle_done)
    );

    cft_state_fsm #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM), .SLOTS(SLOTS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
        .tx_ovf_i(tx_ovf), .restart_i(restart_req_i), .idle_done_i(idle_done),
        .busoff_o(busoff), .cnt_hold_o(hold), .cnt_clr_o(clr), .recover_en_o(rec_en),
        .event_o(state_event_o), .abort_o(tx_abort_o), .abort_mask_o(tx_abort_mask_o)
    );

    always_comb begin
        status_o = '0;
        status_o[STAT_RX_LSB +: CNT_W] = rx_cnt;
        status_o[STAT_TX_LSB +: CNT_W] = tx_cnt;
        status_o[STAT_WARN_POS] = (rx_cnt >= WARN_C) || (tx_cnt >= WARN_C);
        status_o[STAT_PASS_POS] = (rx_cnt >= PASS_C) || (tx_cnt >= PASS_C);
        status_o[STAT_BOFF_POS] = busoff;
    end

    // R5: bus-off always shows a saturated transmit counter
    assert_busoff_tx_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STAT_BOFF_POS] |-> (status_o[STAT_TX_LSB +: CNT_W] == {CNT_W{1'b1}}));

    // R7: the status word is frozen while waiting for restart
    assert_status_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busoff) && busoff && !clr) |-> $stable(status_o));

endmodule

// File: tb/can_fault_tracker_tb_top.sv
module can_fault_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_inc = 0, rx_dec = 0, tx_inc = 0, tx_dec = 0;
    logic        bvalid = 0, blevel = 1, restart = 0;
    logic [31:0] status;
    logic        ev, abort;
    logic [15:0] amask;

    int n_checks = 0;
    int n_fail   = 0;
    int ev_cnt   = 0;
    int ab_cnt   = 0;
    logic [15:0] ab_mask = '0;
    int cycles   = 0;

    localparam logic [31:0] WARN = 32'h0002_0000;
    localparam logic [31:0] PASS = 32'h0004_0000;
    localparam logic [31:0] BOFF = 32'h0008_0000;
    localparam logic [31:0] BUSOFF_STATUS = 32'h0000_FF00 | WARN | PASS | BOFF;

    always #2 clk = ~clk;

    can_fault_tracker dut_i (
        .clk(clk), .rst_n(rst_n),
        .rx_err_inc_i(rx_inc), .rx_err_dec_i(rx_dec),
        .tx_err_inc_i(tx_inc), .tx_err_dec_i(tx_dec),
        .bit_valid_i(bvalid), .bit_level_i(blevel), .restart_req_i(restart),
        .status_o(status), .state_event_o(ev),
        .tx_abort_o(abort), .tx_abort_mask_o(amask)
    );

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && ev) ev_cnt <= ev_cnt + 1;
        if (rst_n && abort) begin
            ab_cnt  <= ab_cnt + 1;
            ab_mask <= amask;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {rx_inc, rx_dec, tx_inc, tx_dec, bvalid, restart} = '0;
        blevel = 1'b1;
        settle(2);
        rst_n = 1'b1;
        settle(1);
        ev_cnt = 0;
        ab_cnt = 0;
    endtask

    task automatic strobe(input logic ri, input logic rd, input logic ti, input logic td, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {rx_inc, rx_dec, tx_inc, tx_dec} = {ri, rd, ti, td};
        end
        @(negedge clk);
        {rx_inc, rx_dec, tx_inc, tx_dec} = '0;
        settle(2);
    endtask

    task automatic send_bits(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bvalid = 1'b1;
            blevel = lvl;
        end
        @(negedge clk);
        bvalid = 1'b0;
        blevel = 1'b1;
        settle(1);
    endtask

    task automatic pulse_restart();
        @(negedge clk);
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        settle(1);
    endtask

    task automatic enter_busoff();
        do_reset();
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 32);
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 reset status", status, 32'h0);
        check("R6 reset abort", {31'b0, abort}, 32'h0);
        check("R6 idle mask", {16'b0, amask}, 32'h0);
    endtask

    task automatic test_rx_count();
        do_reset();
        strobe(1'b1, 1'b0, 1'b0, 1'b0, 3);
        check("R2 rx inc", status, 32'd3);
        strobe(1'b0, 1'b1, 1'b0, 1'b0, 1);
        check("R2 rx dec", status, 32'd2);
        strobe(1'b1, 1'b1, 1'b0, 1'b0, 1);
        check("R2 inc wins", status, 32'd3);
        strobe(1'b0, 1'b1, 1'b0, 1'b0, 5);
        check("R2 floor", status, 32'd0);
        check("R1 no event", ev_cnt, 0);
    endtask

    task automatic test_tx_levels();
        do_reset();
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 11);
        check("R2 tx step", status, 32'h0000_5800);
        check("R4 no event below warn", ev_cnt, 0);
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 1);
        check("R3 tx warning", status, 32'h0000_6000 | WARN);
        check("R4 warning event", ev_cnt, 1);
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 4);
        check("R3 tx passive", status, 32'h0000_8000 | WARN | PASS);
        check("R4 passive event", ev_cnt, 2);
        strobe(1'b0, 1'b0, 1'b0, 1'b1, 1);
        check("R3 back to warning", status, 32'h0000_7F00 | WARN);
        check("R4 downward event", ev_cnt, 3);
    endtask

    task automatic test_rx_warning();
        do_reset();
        strobe(1'b1, 1'b0, 1'b0, 1'b0, 96);
        check("R3 rx warning", status, 32'h0000_0060 | WARN);
        check("R4 rx warning event", ev_cnt, 1);
    endtask

    task automatic test_busoff();
        do_reset();
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 31);
        check("R5 before busoff", status, 32'h0000_F800 | WARN | PASS);
        check("R6 no abort yet", ab_cnt, 0);
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 1);
        check("R5 busoff status", status, BUSOFF_STATUS);
        check("R5 events", ev_cnt, 3);
        check("R6 abort once", ab_cnt, 1);
        check("R6 abort mask", {16'b0, ab_mask}, 32'h0000_FFFF);
        strobe(1'b1, 1'b0, 1'b0, 1'b1, 3);
        check("R7 strobes ignored", status, BUSOFF_STATUS);
        check("R6 mask cleared", {16'b0, amask}, 32'h0);
        send_bits(1500, 1'b1);
        check("R8 no early count", status, BUSOFF_STATUS);
    endtask

    task automatic test_recovery();
        int e0;
        enter_busoff();
        pulse_restart();
        e0 = ev_cnt;
        send_bits(10, 1'b1);
        send_bits(1, 1'b0);
        send_bits(1407, 1'b1);
        check("R10 dominant restarts run", status, BUSOFF_STATUS);
        check("R10 no event yet", ev_cnt, e0);
        send_bits(1, 1'b1);
        check("R9 recovered", status, 32'h0);
        check("R9 recovery event", ev_cnt, e0 + 1);
    endtask

    task automatic test_restart_ignored();
        do_reset();
        strobe(1'b0, 1'b0, 1'b1, 1'b0, 1);
        pulse_restart();
        send_bits(1408, 1'b1);
        check("R8 restart ignored", status, 32'h0000_0800);
        check("R8 no event", ev_cnt, 0);
    endtask

    task automatic test_coincide();
        enter_busoff();
        @(negedge clk);
        restart = 1'b1;
        bvalid  = 1'b1;
        blevel  = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        bvalid  = 1'b0;
        send_bits(1407, 1'b1);
        check("R8 bit with restart not counted", status, BUSOFF_STATUS);
        @(negedge clk);
        bvalid = 1'b1;
        blevel = 1'b1;
        rx_inc = 1'b1;
        tx_inc = 1'b1;
        @(negedge clk);
        bvalid = 1'b0;
        rx_inc = 1'b0;
        tx_inc = 1'b0;
        settle(2);
        check("R11 clear beats strobes", status, 32'h0);
    endtask

    initial begin
        test_reset();
        test_rx_count();
        test_tx_levels();
        test_rx_warning();
        test_busoff();
        test_recovery();
        test_restart_ignored();
        test_coincide();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule